// File: doc/BRIEF.md
# Multi-Mode Lookup-Table RAM Slice

This block models one logic slice whose four 64-bit lookup-table storage elements double as distributed RAM. The elements carry the roles D, C, B and A. A static configuration gives each element one of five modes: plain logic (no RAM), 32x2 single-port, 32x2 dual-port, 64x1 single-port or 64x1 dual-port. A slice-wide setting can also join the four elements into 128x1 or 256x1 storage. The block decodes that configuration and flags illegal combinations. From each element's six address pins, its two bypass inputs, a shared write enable and two extra write-select bits, it steers a write address, a read address and write data into every element. Each element has two read outputs. Three wide outputs select among element outputs when the elements are aggregated.

The D element is the master source of write addresses. Dual-port elements write at the address on the D pins and read at their own pins. Element A takes its write data through element B's data path. Reads are combinational. Writes happen on the rising clock edge. An active-low asynchronous reset clears all storage.

Top module: `lutram_slice`

## Requirements
- R1: Reset clears all 256 storage bits, so every read output is 0 right after reset, whatever the address.
- R2: If any element is in a RAM mode (codes 1..4) while D is in logic mode (code 0), `cfg_illegal` is 1.
- R3: If D is in a dual-port mode (code 2 = 32x2 dual or code 4 = 64x1 dual), `cfg_illegal` is 1.
- R4: `cfg_illegal` is 1 in each of these cases: an element mode code of 5..7; `cfg_wide` = 3; or `cfg_wide` of 1 (128x1) or 2 (256x1) while any element is not in mode 3 or 4.
- R5: While `cfg_illegal` is 1, no element is written.
- R6: In 64x1 single-port mode (code 3), an element writes and reads at its own `pin_addr` bits [5:0], with write data from its own `byp_lo`. Its `out_hi` shows the stored bit and its `out_lo` is 0.
- R7: In 32x2 single-port mode (code 1), an element uses its own `pin_addr` bits [4:0] and ignores bit 5. It writes {`byp_hi`, `byp_lo`} as {bit1, bit0}. It returns bit1 on `out_hi` and bit0 on `out_lo`.
- R8: In dual-port modes, elements C and B write at the D element's `pin_addr` (bits [4:0] for 32x2, bits [5:0] for 64x1) and read at their own. Their data bit0 is D's `byp_lo` and their 32x2 data bit1 is their own `byp_hi`.
- R9: In dual-port modes (or either wide mode), element A writes data bit0 equal to element B's steered data bit0. This is B's own `byp_lo` when B is single-port, and D's `byp_lo` otherwise.
- R10: In 128x1 mode (`cfg_wide` = 1), every element writes at D's address with D's `byp_lo`. `wsel_lo` = 1 writes D and B, and `wsel_lo` = 0 writes C and A.
- R11: In 256x1 mode (`cfg_wide` = 2), only the element with index {`wsel_hi`,`wsel_lo`} is written. The index is 3 for D, 2 for C, 1 for B and 0 for A.
- R12: `wide_dc` = `byp_hi`[C] ? `out_hi`[D] : `out_hi`[C]. `wide_ba` = `byp_hi`[A] ? `out_hi`[B] : `out_hi`[A]. `wide_all` = `byp_hi`[B] ? `wide_dc` : `wide_ba`.
- R13: An element in logic mode (code 0) is never written and drives 0 on both outputs.
- R14: No element is written in a cycle where `we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears storage |
| cfg_elem_mode | input | 12 | Per-element 3-bit mode code, D in [11:9], C [8:6], B [5:3], A [2:0] |
| cfg_wide | input | 2 | 0 none, 1 128x1, 2 256x1, 3 reserved |
| pin_addr | input | 24 | Six address pins per element, element e at [6e+5:6e] (A = 0 .. D = 3) |
| byp_hi | input | 4 | Upper bypass input per element, indexed by element |
| byp_lo | input | 4 | Lower bypass input per element, indexed by element |
| wsel_lo | input | 1 | Low extra write-select bit for wide modes |
| wsel_hi | input | 1 | High extra write-select bit for 256x1 |
| we | input | 1 | Shared write enable |
| out_hi | output | 4 | Primary read output per element |
| out_lo | output | 4 | Secondary read output per element (32x2 bit0) |
| wide_dc | output | 1 | Selection between D and C outputs |
| wide_ba | output | 1 | Selection between B and A outputs |
| wide_all | output | 1 | Selection between the two pair outputs |
| cfg_illegal | output | 1 | Configuration is not allowed |

## Verification
The properties assume that the configuration inputs change only between writes, and that `we`, `wsel_lo` and `wsel_hi` are steady around each rising edge. The properties compare the internal per-element write strobes with the configuration and the write-select ports. The bench changes every input half a cycle away from the write edge and asserts `we` for exactly one edge per write. It re-applies reset before each directed scenario, so that earlier writes cannot hide a missing or stray write.

// File: rtl/lutram_slice_pkg.sv
package lutram_slice_pkg;

  localparam int NUM_ELEM = 4;
  localparam int MODE_W   = 3;
  localparam int WIDE_W   = 2;

  // element roles; index doubles as the 256x1 write-select code
  localparam int ELEM_A = 0;
  localparam int ELEM_B = 1;
  localparam int ELEM_C = 2;
  localparam int ELEM_D = 3;

  localparam logic [MODE_W-1:0] EM_LOGIC = 3'd0;
  localparam logic [MODE_W-1:0] EM_S32   = 3'd1;
  localparam logic [MODE_W-1:0] EM_D32   = 3'd2;
  localparam logic [MODE_W-1:0] EM_S64   = 3'd3;
  localparam logic [MODE_W-1:0] EM_D64   = 3'd4;

  localparam logic [WIDE_W-1:0] WM_NONE  = 2'd0;
  localparam logic [WIDE_W-1:0] WM_128   = 2'd1;
  localparam logic [WIDE_W-1:0] WM_256   = 2'd2;

  function automatic logic mode_known(logic [MODE_W-1:0] m);
    return m <= EM_D64;
  endfunction

  function automatic logic mode_is_ram(logic [MODE_W-1:0] m);
    return (m != EM_LOGIC) && (m <= EM_D64);
  endfunction

  function automatic logic mode_is_dual(logic [MODE_W-1:0] m);
    return (m == EM_D32) || (m == EM_D64);
  endfunction

  function automatic logic mode_is_64(logic [MODE_W-1:0] m);
    return (m == EM_S64) || (m == EM_D64);
  endfunction

  function automatic logic wide_on(logic [WIDE_W-1:0] w);
    return (w == WM_128) || (w == WM_256);
  endfunction

  // which element a wide-mode write reaches
  function automatic logic wide_hit(logic [WIDE_W-1:0] w, logic sel_hi,
                                    logic sel_lo, logic [1:0] idx);
    logic hit;
    case (w)
      WM_128:  hit = idx[0] ? sel_lo : !sel_lo;
      WM_256:  hit = ({sel_hi, sel_lo} == idx);
      default: hit = 1'b1;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/lutram_cfg_check.sv
module lutram_cfg_check
  import lutram_slice_pkg::*;
#(
  parameter int N_EL  = NUM_ELEM,
  parameter int MW    = MODE_W,
  parameter int WW    = WIDE_W,
  parameter int D_IDX = ELEM_D
) (
  input  logic [N_EL*MW-1:0] cfg_elem_mode,
  input  logic [WW-1:0]      cfg_wide,
  output logic               cfg_illegal
);

  logic [MW-1:0] d_mode;
  logic          any_ram;
  logic          bad_code;
  logic          bad_wide;

  assign d_mode = cfg_elem_mode[D_IDX*MW +: MW];

  always_comb begin
    any_ram  = 1'b0;
    bad_code = 1'b0;
    bad_wide = (cfg_wide == 2'd3);
    for (int e = 0; e < N_EL; e++) begin
      if (!mode_known(cfg_elem_mode[e*MW +: MW]))
        bad_code = 1'b1;
      if (mode_is_ram(cfg_elem_mode[e*MW +: MW]))
        any_ram = 1'b1;
      if (wide_on(cfg_wide) && !mode_is_64(cfg_elem_mode[e*MW +: MW]))
        bad_wide = 1'b1;
    end
  end

  assign cfg_illegal = bad_code || bad_wide
                    || (any_ram && !mode_is_ram(d_mode))
                    || mode_is_dual(d_mode);

endmodule

// File: rtl/lutram_steer.sv
module lutram_steer
  import lutram_slice_pkg::*;
#(
  parameter int IDX = 0,
  parameter int AW  = 6,
  parameter int MW  = MODE_W,
  parameter int WW  = WIDE_W
) (
  input  logic [MW-1:0] mode,
  input  logic [WW-1:0] wide,
  input  logic          illegal,
  input  logic [AW-1:0] own_addr,
  input  logic          own_hi,
  input  logic          own_lo,
  input  logic [AW-1:0] d_addr,
  input  logic          d_lo,
  input  logic          b_bit0,
  input  logic          we,
  input  logic          sel_hi,
  input  logic          sel_lo,
  output logic [AW-1:0] wa,
  output logic [AW-1:0] ra,
  output logic [1:0]    di,
  output logic          wr_en,
  output logic          is64,
  output logic          ram_on
);

  localparam logic [1:0] IDX2   = 2'(IDX);
  localparam bit         IS_A   = (IDX == ELEM_A);
  localparam int         HAW    = AW - 1;

  logic          dual;
  logic [AW-1:0] wa_src;

  assign is64   = mode_is_64(mode);
  assign ram_on = mode_is_ram(mode);
  assign dual   = mode_is_dual(mode) || wide_on(wide);
  assign wa_src = dual ? d_addr : own_addr;

  // 32x2 storage: top address bit is reserved for the bit index
  assign wa = is64 ? wa_src   : {1'b0, wa_src[HAW-1:0]};
  assign ra = is64 ? own_addr : {1'b0, own_addr[HAW-1:0]};

  generate
    if (IS_A) begin : g_a_data
      assign di[0] = dual ? b_bit0 : own_lo;
    end else begin : g_other_data
      assign di[0] = dual ? d_lo : own_lo;
    end
  endgenerate
  assign di[1] = own_hi;

  assign wr_en = we && ram_on && !illegal && wide_hit(wide, sel_hi, sel_lo, IDX2);

endmodule

// File: rtl/lutram_cell.sv
module lutram_cell #(
  parameter int AW    = 6,
  parameter int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          is64,
  input  logic          ram_on,
  input  logic [AW-1:0] wa,
  input  logic [1:0]    di,
  input  logic [AW-1:0] ra,
  output logic          o_hi,
  output logic          o_lo
);

  localparam int HAW = AW - 1;

  logic [DEPTH-1:0] mem;
  logic [HAW-1:0]   wa_h;
  logic [HAW-1:0]   ra_h;

  assign wa_h = wa[HAW-1:0];
  assign ra_h = ra[HAW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      if (is64) begin
        mem[wa] <= di[0];
      end else begin
        mem[{1'b0, wa_h}] <= di[0];
        mem[{1'b1, wa_h}] <= di[1];
      end
    end
  end

  assign o_hi = ram_on && (is64 ? mem[ra] : mem[{1'b1, ra_h}]);
  assign o_lo = ram_on && !is64 && mem[{1'b0, ra_h}];

endmodule

// File: rtl/lutram_slice.sv
module lutram_slice
  import lutram_slice_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ELEM*MODE_W-1:0] cfg_elem_mode,
  input  logic [WIDE_W-1:0]        cfg_wide,
  input  logic [NUM_ELEM*AW-1:0]   pin_addr,
  input  logic [NUM_ELEM-1:0]      byp_hi,
  input  logic [NUM_ELEM-1:0]      byp_lo,
  input  logic                     wsel_lo,
  input  logic                     wsel_hi,
  input  logic                     we,
  output logic [NUM_ELEM-1:0]      out_hi,
  output logic [NUM_ELEM-1:0]      out_lo,
  output logic                     wide_dc,
  output logic                     wide_ba,
  output logic                     wide_all,
  output logic                     cfg_illegal
);

  // named internal events for the checker
  logic [NUM_ELEM-1:0] elem_we;
  logic [NUM_ELEM-1:0] elem_is64;
  logic [NUM_ELEM-1:0] elem_ram;
  logic [AW-1:0]       elem_wa [NUM_ELEM];
  logic [AW-1:0]       elem_ra [NUM_ELEM];
  logic [1:0]          elem_di [NUM_ELEM];
  logic [AW-1:0]       d_addr;

  assign d_addr = pin_addr[ELEM_D*AW +: AW];

  lutram_cfg_check #(
    .N_EL (NUM_ELEM),
    .MW   (MODE_W),
    .WW   (WIDE_W),
    .D_IDX(ELEM_D)
  ) cfg_i (
    .cfg_elem_mode(cfg_elem_mode),
    .cfg_wide     (cfg_wide),
    .cfg_illegal  (cfg_illegal)
  );

  generate
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
      lutram_steer #(
        .IDX(e),
        .AW (AW),
        .MW (MODE_W),
        .WW (WIDE_W)
      ) steer_i (
        .mode    (cfg_elem_mode[e*MODE_W +: MODE_W]),
        .wide    (cfg_wide),
        .illegal (cfg_illegal),
        .own_addr(pin_addr[e*AW +: AW]),
        .own_hi  (byp_hi[e]),
        .own_lo  (byp_lo[e]),
        .d_addr  (d_addr),
        .d_lo    (byp_lo[ELEM_D]),
        .b_bit0  (elem_di[ELEM_B][0]),
        .we      (we),
        .sel_hi  (wsel_hi),
        .sel_lo  (wsel_lo),
        .wa      (elem_wa[e]),
        .ra      (elem_ra[e]),
        .di      (elem_di[e]),
        .wr_en   (elem_we[e]),
        .is64    (elem_is64[e]),
        .ram_on  (elem_ram[e])
      );

      lutram_cell #(
        .AW(AW)
      ) cell_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (elem_we[e]),
        .is64  (elem_is64[e]),
        .ram_on(elem_ram[e]),
        .wa    (elem_wa[e]),
        .di    (elem_di[e]),
        .ra    (elem_ra[e]),
        .o_hi  (out_hi[e]),
        .o_lo  (out_lo[e])
      );
    end
  endgenerate

  // output selection for aggregated storage
  assign wide_dc  = byp_hi[ELEM_C] ? out_hi[ELEM_D] : out_hi[ELEM_C];
  assign wide_ba  = byp_hi[ELEM_A] ? out_hi[ELEM_B] : out_hi[ELEM_A];
  assign wide_all = byp_hi[ELEM_B] ? wide_dc : wide_ba;

endmodule

// File: rtl/lutram_slice_chk.sv
module lutram_slice_chk
  import lutram_slice_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_ELEM*MODE_W-1:0] cfg_elem_mode,
  input logic [WIDE_W-1:0]          cfg_wide,
  input logic                       we,
  input logic                       wsel_lo,
  input logic                       cfg_illegal,
  input logic [NUM_ELEM-1:0]        elem_we,
  input logic [NUM_ELEM-1:0]        out_hi,
  input logic [NUM_ELEM-1:0]        out_lo
);

  logic [MODE_W-1:0] d_mode;
  logic              others_ram;
  assign d_mode = cfg_elem_mode[ELEM_D*MODE_W +: MODE_W];
  assign others_ram = mode_is_ram(cfg_elem_mode[ELEM_C*MODE_W +: MODE_W])
                   || mode_is_ram(cfg_elem_mode[ELEM_B*MODE_W +: MODE_W])
                   || mode_is_ram(cfg_elem_mode[ELEM_A*MODE_W +: MODE_W]);

  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_hi == '0 && out_lo == '0));

  a_r2_d_must_be_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (d_mode == EM_LOGIC && others_ram) |-> cfg_illegal);

  a_r3_d_never_dual: assert property (@(posedge clk) disable iff (!rst_n)
    (d_mode == EM_D32 || d_mode == EM_D64) |-> cfg_illegal);

  a_r5_quiet_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (elem_we == '0));

  a_r10_pair_split: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wide == WM_128 && !cfg_illegal && we) |->
      ($countones(elem_we) == 2 && elem_we[ELEM_D] == wsel_lo && elem_we[ELEM_C] == !wsel_lo));

  a_r11_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wide == WM_256) |-> $onehot0(elem_we));

  a_r14_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> (elem_we == '0));

  generate
    for (genvar e = 0; e < NUM_ELEM; e++) begin : g_logic_chk
      a_r13_logic_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_elem_mode[e*MODE_W +: MODE_W] == EM_LOGIC) |->
          (!elem_we[e] && !out_hi[e] && !out_lo[e]));
    end
  endgenerate

endmodule

bind lutram_slice lutram_slice_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_elem_mode(cfg_elem_mode),
  .cfg_wide     (cfg_wide),
  .we           (we),
  .wsel_lo      (wsel_lo),
  .cfg_illegal  (cfg_illegal),
  .elem_we      (elem_we),
  .out_hi       (out_hi),
  .out_lo       (out_lo)
);

// File: tb/lutram_slice_tb_top.sv
`timescale 1ns/100ps
module lutram_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_elem_mode = '0;
  logic [1:0]  cfg_wide = '0;
  logic [23:0] pin_addr = '0;
  logic [3:0]  byp_hi = '0;
  logic [3:0]  byp_lo = '0;
  logic        wsel_lo = 1'b0;
  logic        wsel_hi = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  out_hi;
  logic [3:0]  out_lo;
  logic        wide_dc;
  logic        wide_ba;
  logic        wide_all;
  logic        cfg_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  lutram_slice dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_elem_mode(cfg_elem_mode), .cfg_wide(cfg_wide),
    .pin_addr(pin_addr), .byp_hi(byp_hi), .byp_lo(byp_lo), .wsel_lo(wsel_lo),
    .wsel_hi(wsel_hi), .we(we), .out_hi(out_hi), .out_lo(out_lo),
    .wide_dc(wide_dc), .wide_ba(wide_ba), .wide_all(wide_all), .cfg_illegal(cfg_illegal)
  );

  // {mode D,C,B,A as octal digits, wide code, expected illegal}
  localparam int NV = 12;
  localparam logic [14:0] CFG_VEC [NV] = '{
    {12'o0000, 2'd0, 1'b0},
    {12'o3333, 2'd0, 1'b0},
    {12'o0300, 2'd0, 1'b1},  // R2
    {12'o4333, 2'd0, 1'b1},  // R3
    {12'o2111, 2'd0, 1'b1},  // R3
    {12'o1222, 2'd0, 1'b0},
    {12'o3353, 2'd0, 1'b1},  // R4 code 5
    {12'o3133, 2'd1, 1'b1},  // R4 wide with 32x2
    {12'o3333, 2'd3, 1'b1},  // R4 reserved wide
    {12'o3333, 2'd2, 1'b0},
    {12'o3444, 2'd1, 1'b0},
    {12'o0000, 2'd1, 1'b1}   // R4
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    we = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [5:0] d, input logic [5:0] c,
                          input logic [5:0] b, input logic [5:0] a);
    pin_addr = {d, c, b, a};
  endtask

  task automatic wr_cycle();
    we = 1'b1;
    @(posedge clk); #1; we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL R14 watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // configuration legality table (R2, R3, R4)
    @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      cfg_elem_mode = CFG_VEC[v][14:3];
      cfg_wide      = CFG_VEC[v][2:1];
      #1;
      check($sformatf("R2/R3/R4 legality vec %0d", v), {7'd0, cfg_illegal}, {7'd0, CFG_VEC[v][0]});
    end

    // R1 reset state
    cfg_elem_mode = 12'o3333; cfg_wide = 2'd0;
    do_reset();
    set_addr(6'd0, 6'd17, 6'd42, 6'd63);
    @(negedge clk);
    check("R1 reset 64x1", {out_hi, out_lo}, 8'h00);
    cfg_elem_mode = 12'o1111; #1;
    check("R1 reset 32x2", {out_hi, out_lo}, 8'h00);

    // R6 single-port 64x1
    cfg_elem_mode = 12'o3333;
    do_reset();
    set_addr(6'd10, 6'd11, 6'd12, 6'd13); byp_lo = 4'b1010; byp_hi = 4'b1111;
    wr_cycle();
    check("R6 64x1 own address", {out_hi, out_lo}, {4'b1010, 4'b0000});
    set_addr(6'd20, 6'd20, 6'd20, 6'd20); #1;
    check("R6 64x1 other address", {4'b0, out_hi}, 8'h00);

    // R7 single-port 32x2, pin 6 ignored
    cfg_elem_mode = 12'o1111;
    do_reset();
    set_addr(6'd35, 6'd35, 6'd35, 6'd35); byp_hi = 4'b1100; byp_lo = 4'b0110;
    wr_cycle();
    set_addr(6'd3, 6'd3, 6'd3, 6'd3); #1;
    check("R7 32x2 pair", {out_hi, out_lo}, {4'b1100, 4'b0110});

    // R8 R9 dual-port 64x1 from D address
    cfg_elem_mode = 12'o3444;
    do_reset();
    set_addr(6'd7, 6'd40, 6'd40, 6'd40); byp_lo = 4'b1000; byp_hi = 4'b0000;
    wr_cycle();
    set_addr(6'd7, 6'd7, 6'd7, 6'd7); #1;
    check("R8 R9 dual 64x1 written at D address", {4'b0, out_hi}, 8'h0F);
    set_addr(6'd40, 6'd40, 6'd40, 6'd40); #1;
    check("R8 dual not at own write pins", {4'b0, out_hi}, 8'h00);

    // R9 A follows single-port B data
    cfg_elem_mode = 12'o3334;
    do_reset();
    set_addr(6'd9, 6'd50, 6'd30, 6'd60); byp_lo = 4'b0010;
    wr_cycle();
    set_addr(6'd9, 6'd50, 6'd30, 6'd9); #1;
    check("R9 A takes B data bit", {4'b0, out_hi}, 8'h03);

    // R8 dual-port 32x2
    cfg_elem_mode = 12'o1200;
    do_reset();
    set_addr(6'd5, 6'd20, 6'd0, 6'd0); byp_hi = 4'b0100; byp_lo = 4'b1000;
    wr_cycle();
    set_addr(6'd5, 6'd5, 6'd0, 6'd0); #1;
    check("R8 dual 32x2", {out_hi, out_lo}, {4'b0100, 4'b1100});

    // R10 R12 128x1
    cfg_elem_mode = 12'o3444; cfg_wide = 2'd1;
    do_reset();
    set_addr(6'd12, 6'd0, 6'd0, 6'd0); byp_lo = 4'b1000; wsel_lo = 1'b1;
    wr_cycle();
    set_addr(6'd13, 6'd0, 6'd0, 6'd0); wsel_lo = 1'b0;
    wr_cycle();
    set_addr(6'd12, 6'd12, 6'd12, 6'd12); byp_hi = 4'b0110; #1;
    check("R10 128x1 wsel high", {4'b0, out_hi}, 8'h0A);
    check("R12 wide select at 12", {5'b0, wide_dc, wide_ba, wide_all}, 8'b101);
    set_addr(6'd13, 6'd13, 6'd13, 6'd13); byp_hi = 4'b0001; #1;
    check("R10 128x1 wsel low", {4'b0, out_hi}, 8'h05);
    check("R12 wide select at 13", {5'b0, wide_dc, wide_ba, wide_all}, 8'b100);

    // R11 256x1
    cfg_wide = 2'd2;
    do_reset();
    set_addr(6'd20, 6'd0, 6'd0, 6'd0); byp_lo = 4'b1000; wsel_hi = 1'b0; wsel_lo = 1'b1;
    wr_cycle();
    set_addr(6'd20, 6'd20, 6'd20, 6'd20); #1;
    check("R11 256x1 one target", {4'b0, out_hi}, 8'h02);
    cfg_wide = 2'd0; wsel_lo = 1'b0;

    // R5 illegal configuration writes nothing
    cfg_elem_mode = 12'o4333;
    do_reset();
    set_addr(6'd3, 6'd3, 6'd3, 6'd3); byp_lo = 4'b1111;
    wr_cycle();
    cfg_elem_mode = 12'o3333; #1;
    check("R5 no write while illegal", {4'b0, out_hi}, 8'h00);

    // R13 logic-mode element
    cfg_elem_mode = 12'o3033;
    do_reset();
    set_addr(6'd8, 6'd8, 6'd8, 6'd8); byp_lo = 4'b1111;
    wr_cycle();
    check("R13 logic element silent", {out_hi, out_lo}, {4'b1011, 4'b0000});
    cfg_elem_mode = 12'o3333; #1;
    check("R13 logic element unwritten", {4'b0, out_hi}, 8'h0B);

    // R14 no write without enable
    do_reset();
    set_addr(6'd44, 6'd44, 6'd44, 6'd44); byp_lo = 4'b1111;
    @(posedge clk); @(negedge clk);
    check("R14 we low", {4'b0, out_hi}, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule